// File: doc/BRIEF.md
# SMBus Register Target with Bus Timeouts

This block is a byte-register target for a two-wire SMBus. It watches oversampled clock and data lines and pulls the data line low through an open-drain enable. It recognises START and STOP conditions and answers one fixed 7-bit device address. Through a small register-file port it supports four transaction shapes. Write Byte writes one register. Send Byte only sets the register pointer. Receive Byte returns the register at that pointer. Read Byte is formed from a pointer write, a repeated START and a read.

The block also keeps track of bus health. If the clock is held low for too long, or both lines stay high for too long, the protocol engine drops any transfer in progress and waits for a new START. Both limits are set in microseconds and converted to system clock cycles with a cycles-per-microsecond parameter. This recovery is off after reset. It is switched on by clearing bit 0 of a configuration byte that lives inside the block at register address 0x20.

Top module: `smb_target`

## Requirements
- R1: After reset the SDA pull-down enable and the write strobe are both low, and the configuration byte at 0x20 holds 0x01, so the timeouts are off.
- R2: A Write Byte transfer (START, address with R/W bit 0, register byte, data byte, STOP) is acknowledged on all three bytes and gives exactly one single-cycle write strobe carrying that register address and data.
- R3: A STOP returns the engine to idle. A byte clocked afterwards without a new START is not acknowledged.
- R4: Read Byte (address+W, register, repeated START, address+R) returns the register contents MSB first. After the host's NACK on the ninth clock the target releases SDA before STOP.
- R5: A byte after START whose upper seven bits do not match the device address is not acknowledged. The following bytes are ignored: no acknowledge and no write strobe until the next START.
- R6: Send Byte sets the pointer without a write strobe. Receive Byte returns the pointed register, and a host ACK repeats that same register because the pointer does not advance.
- R7: Register address 0x20 is held inside the block. Writing it raises no write strobe, and reading it returns the stored byte. Bit 0 of this byte disables the timeouts when it is 1.
- R8: While the timeouts are disabled, a clock-low stretch of any length does not abort the transfer.
- R9: While enabled, a clock held low longer than LOW_TMO_US microseconds aborts the transfer. The rest of the byte gets no acknowledge and no write.
- R10: While enabled, both lines held high longer than IDLE_TMO_US microseconds during a transfer abort it.
- R11: A START seen in the same cycle as an expiring idle timeout wins, and the transfer that follows completes normally.
- R12: Each line passes a two-flop synchroniser and a three-sample agreement filter, so pulses of two system clocks or less on SCL have no effect on the transfer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | Raw SMBus clock line level |
| sdaIn | input | 1 | Raw SMBus data line level |
| sdaOe | output | 1 | Pull SDA low when 1 (open-drain enable) |
| regAddr | output | 8 | Register pointer presented to the register file |
| regWdata | output | 8 | Data for a register write |
| regWe | output | 1 | One-cycle register write strobe |
| regRdata | input | 8 | Register file read data at regAddr |

## Verification
The idle-timeout expiry and START detection can land in the same system clock cycle. Both change the engine state, and the START must take priority. The bench makes this happen by sweeping the idle gap between a STOP and the next START over a window of cycles around the timeout length, with the timeouts enabled, so that one gap lines up exactly with the expiry. Each START in the sweep opens a Write Byte. The result is judged by whether every one of those writes is acknowledged and reaches the register file with the right address and data.

// File: rtl/smb_pkg.sv
package smb_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_AACK,
    ST_REG,
    ST_RACK,
    ST_WDAT,
    ST_WACK,
    ST_TX,
    ST_TXACK,
    ST_SKIP
  } smbState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic shiftIn;
    logic loadPtr;
    logic doWrite;
    logic loadTx;
    logic shiftTx;
    logic driveAck;
    logic driveData;
  } smbCtl_t;

  localparam logic [7:0] CFG_REG_ADDR = 8'h20;

endpackage

// File: rtl/smb_line_watch.sv
module smb_line_watch #(
  parameter int FILT_LEN = 3
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclIn,
  input  logic sdaIn,
  output logic sclF,
  output logic sdaF,
  output logic sclRise,
  output logic sclFall,
  output logic startSeen,
  output logic stopSeen
);

  localparam int NUM_LINES = 2;

  logic [NUM_LINES-1:0] rawIn;
  logic [NUM_LINES-1:0] cleanQ;
  logic sclD, sdaD;

  assign rawIn = {sdaIn, sclIn};

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    logic [1:0]          syncQ;
    logic [FILT_LEN-1:0] hist;
    logic                clean;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        syncQ <= '1;
        hist  <= '1;
        clean <= 1'b1;
      end else begin
        syncQ <= {syncQ[0], rawIn[g]};
        hist  <= {hist[FILT_LEN-2:0], syncQ[1]};
        if (&hist)       clean <= 1'b1;
        else if (~|hist) clean <= 1'b0;
      end
    end

    assign cleanQ[g] = clean;
  end

  assign sclF = cleanQ[0];
  assign sdaF = cleanQ[1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclD <= 1'b1;
      sdaD <= 1'b1;
    end else begin
      sclD <= sclF;
      sdaD <= sdaF;
    end
  end

  assign sclRise   = sclF & ~sclD;
  assign sclFall   = ~sclF & sclD;
  assign startSeen = sclF & sclD & sdaD & ~sdaF;
  assign stopSeen  = sclF & sclD & ~sdaD & sdaF;

endmodule

// File: rtl/smb_timeout.sv
module smb_timeout #(
  parameter int LOW_CYC  = 3000000,
  parameter int IDLE_CYC = 15000
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclF,
  input  logic sdaF,
  input  logic tmoOff,
  output logic tmoHit
);

  localparam int LW = $clog2(LOW_CYC + 1);
  localparam int IW = $clog2(IDLE_CYC + 1);
  localparam logic [LW-1:0] LOW_END  = LW'(LOW_CYC - 1);
  localparam logic [LW-1:0] LOW_LIM  = LW'(LOW_CYC);
  localparam logic [IW-1:0] IDLE_END = IW'(IDLE_CYC - 1);
  localparam logic [IW-1:0] IDLE_LIM = IW'(IDLE_CYC);

  logic [LW-1:0] lowCnt;
  logic [IW-1:0] idleCnt;
  logic          bothHigh;

  assign bothHigh = sclF & sdaF;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lowCnt  <= '0;
      idleCnt <= '0;
      tmoHit  <= 1'b0;
    end else begin
      if (tmoOff || sclF)         lowCnt <= '0;
      else if (lowCnt != LOW_LIM) lowCnt <= lowCnt + 1'b1;

      if (tmoOff || !bothHigh)      idleCnt <= '0;
      else if (idleCnt != IDLE_LIM) idleCnt <= idleCnt + 1'b1;

      tmoHit <= !tmoOff && ((!sclF && lowCnt == LOW_END) ||
                            (bothHigh && idleCnt == IDLE_END));
    end
  end

  AST_TMO_QUIET_WHEN_OFF: assert property (@(posedge clk) disable iff (!rstN)
    tmoOff |=> !tmoHit); // R8

endmodule

// File: rtl/smb_ctrl.sv
module smb_ctrl
  import smb_pkg::*;
#(
  parameter logic [6:0] TARGET_ADDR = 7'h2F
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclRise,
  input  logic       sclFall,
  input  logic       startSeen,
  input  logic       stopSeen,
  input  logic       tmoHit,
  input  logic       sdaF,
  input  logic [7:0] rxByte,
  output smbCtl_t    ctl
);

  smbState_t  state, stateN;
  logic [2:0] bitCnt, bitN;
  logic       byteDone, doneN;
  logic       rwBit, rwN;
  logic       hostAck, ackN;

  always_comb begin
    stateN = state;
    bitN   = bitCnt;
    doneN  = byteDone;
    rwN    = rwBit;
    ackN   = hostAck;
    ctl    = '0;
    ctl.driveAck  = state inside {ST_AACK, ST_RACK, ST_WACK};
    ctl.driveData = (state == ST_TX);

    if (stopSeen) begin
      stateN = ST_IDLE;
      bitN   = '0;
      doneN  = 1'b0;
    end else if (startSeen) begin
      stateN = ST_ADDR;
      bitN   = '0;
      doneN  = 1'b0;
    end else if (tmoHit) begin
      stateN = ST_IDLE;
      bitN   = '0;
      doneN  = 1'b0;
    end else begin
      case (state)
        ST_ADDR, ST_REG, ST_WDAT: begin
          if (sclRise) begin
            ctl.shiftIn = 1'b1;
            bitN = bitCnt + 3'd1;
            if (bitCnt == 3'd7) doneN = 1'b1;
          end else if (sclFall && byteDone) begin
            doneN = 1'b0;
            bitN  = '0;
            case (state)
              ST_ADDR: begin
                if (rxByte[7:1] == TARGET_ADDR) begin
                  stateN = ST_AACK;
                  rwN    = rxByte[0];
                end else begin
                  stateN = ST_SKIP;
                end
              end
              ST_REG: begin
                ctl.loadPtr = 1'b1;
                stateN = ST_RACK;
              end
              default: begin
                ctl.doWrite = 1'b1;
                stateN = ST_WACK;
              end
            endcase
          end
        end
        ST_AACK: begin
          if (sclFall) begin
            if (rwBit) begin
              ctl.loadTx = 1'b1;
              stateN = ST_TX;
            end else begin
              stateN = ST_REG;
            end
          end
        end
        ST_RACK:  if (sclFall) stateN = ST_WDAT;
        ST_WACK:  if (sclFall) stateN = ST_SKIP;
        ST_TX: begin
          if (sclFall) begin
            ctl.shiftTx = 1'b1;
            bitN = bitCnt + 3'd1;
            if (bitCnt == 3'd7) stateN = ST_TXACK;
          end
        end
        ST_TXACK: begin
          if (sclRise) begin
            ackN = !sdaF;
          end else if (sclFall) begin
            if (hostAck) begin
              ctl.loadTx = 1'b1;
              stateN = ST_TX;
            end else begin
              stateN = ST_SKIP;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      bitCnt   <= '0;
      byteDone <= 1'b0;
      rwBit    <= 1'b0;
      hostAck  <= 1'b0;
    end else begin
      state    <= stateN;
      bitCnt   <= bitN;
      byteDone <= doneN;
      rwBit    <= rwN;
      hostAck  <= ackN;
    end
  end

  AST_STOP_TO_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    stopSeen |=> state == ST_IDLE); // R3
  AST_START_WINS: assert property (@(posedge clk) disable iff (!rstN)
    (startSeen && !stopSeen) |=> state == ST_ADDR); // R11
  AST_TMO_ABORT: assert property (@(posedge clk) disable iff (!rstN)
    (tmoHit && !startSeen) |=> state == ST_IDLE); // R9

endmodule

// File: rtl/smb_datapath.sv
module smb_datapath
  import smb_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  smbCtl_t    ctl,
  input  logic       sdaF,
  input  logic [7:0] regRdata,
  output logic [7:0] rxByte,
  output logic       sdaOe,
  output logic [7:0] regAddr,
  output logic [7:0] regWdata,
  output logic       regWe,
  output logic       tmoOff
);

  logic [7:0] rxReg, txReg, ptrReg, cfgReg;
  logic       ptrIsCfg;

  assign ptrIsCfg = (ptrReg == CFG_REG_ADDR);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxReg    <= '0;
      txReg    <= '1;
      ptrReg   <= '0;
      cfgReg   <= 8'h01;
      regWe    <= 1'b0;
      regWdata <= '0;
      sdaOe    <= 1'b0;
    end else begin
      regWe <= 1'b0;
      if (ctl.shiftIn) rxReg <= {rxReg[6:0], sdaF};
      if (ctl.loadPtr) ptrReg <= rxReg;
      if (ctl.doWrite) begin
        if (ptrIsCfg) begin
          cfgReg <= rxReg;
        end else begin
          regWe    <= 1'b1;
          regWdata <= rxReg;
        end
      end
      if (ctl.loadTx)       txReg <= ptrIsCfg ? cfgReg : regRdata;
      else if (ctl.shiftTx) txReg <= {txReg[6:0], 1'b1};
      sdaOe <= ctl.driveAck | (ctl.driveData & ~txReg[7]);
    end
  end

  assign rxByte  = rxReg;
  assign regAddr = ptrReg;
  assign tmoOff  = cfgReg[0];

  AST_WE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    regWe |=> !regWe); // R2
  AST_CFG_NOT_EXPORTED: assert property (@(posedge clk) disable iff (!rstN)
    regWe |-> regAddr != CFG_REG_ADDR); // R7

endmodule

// File: rtl/smb_target.sv
module smb_target
  import smb_pkg::*;
#(
  parameter logic [6:0] TARGET_ADDR = 7'h2F,
  parameter int CLK_PER_US  = 100,
  parameter int LOW_TMO_US  = 30000,
  parameter int IDLE_TMO_US = 150,
  parameter int FILT_LEN    = 3
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  output logic       sdaOe,
  output logic [7:0] regAddr,
  output logic [7:0] regWdata,
  output logic       regWe,
  input  logic [7:0] regRdata
);

  localparam int LOW_CYC  = CLK_PER_US * LOW_TMO_US;
  localparam int IDLE_CYC = CLK_PER_US * IDLE_TMO_US;

  logic sclF, sdaF, sclRise, sclFall, startSeen, stopSeen;
  logic tmoHit, tmoOff;
  logic [7:0] rxByte;
  smbCtl_t ctl;

  smb_line_watch #(.FILT_LEN(FILT_LEN)) i_watch (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .sclF(sclF), .sdaF(sdaF), .sclRise(sclRise), .sclFall(sclFall),
    .startSeen(startSeen), .stopSeen(stopSeen)
  );

  smb_timeout #(.LOW_CYC(LOW_CYC), .IDLE_CYC(IDLE_CYC)) i_tmo (
    .clk(clk), .rstN(rstN), .sclF(sclF), .sdaF(sdaF),
    .tmoOff(tmoOff), .tmoHit(tmoHit)
  );

  smb_ctrl #(.TARGET_ADDR(TARGET_ADDR)) i_ctrl (
    .clk(clk), .rstN(rstN), .sclRise(sclRise), .sclFall(sclFall),
    .startSeen(startSeen), .stopSeen(stopSeen), .tmoHit(tmoHit),
    .sdaF(sdaF), .rxByte(rxByte), .ctl(ctl)
  );

  smb_datapath i_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .sdaF(sdaF), .regRdata(regRdata),
    .rxByte(rxByte), .sdaOe(sdaOe), .regAddr(regAddr),
    .regWdata(regWdata), .regWe(regWe), .tmoOff(tmoOff)
  );

endmodule

// File: tb/test_smb_target.sv
`timescale 1ns/1ps
module test_smb_target;

  localparam logic [6:0] DEV = 7'h2F;
  localparam int IDLE_CYC = 2 * 40;
  localparam int Q = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclH = 1'b1;
  logic sdaH = 1'b1;
  logic sdaOe, regWe, sdaLine;
  logic [7:0] regAddr, regWdata, regRdata;
  logic [7:0] mem [256];
  int weCnt;
  logic [7:0] lastA, lastD;
  int nChk = 0;
  int nBad = 0;

  always #2 clk = ~clk;

  assign sdaLine  = sdaH & ~sdaOe;
  assign regRdata = mem[regAddr];

  smb_target #(.TARGET_ADDR(DEV), .CLK_PER_US(2), .LOW_TMO_US(100),
               .IDLE_TMO_US(40), .FILT_LEN(3)) i_smb_target (
    .clk(clk), .rstN(rstN), .sclIn(sclH), .sdaIn(sdaLine), .sdaOe(sdaOe),
    .regAddr(regAddr), .regWdata(regWdata), .regWe(regWe), .regRdata(regRdata)
  );

  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < 256; i++) mem[i] <= 8'(i) ^ 8'h5A;
      weCnt <= 0;
      lastA <= '0;
      lastD <= '0;
    end else if (regWe) begin
      mem[regAddr] <= regWdata;
      weCnt <= weCnt + 1;
      lastA <= regAddr;
      lastD <= regWdata;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nChk++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic waitC(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic startC();
    sdaH <= 1'b1; waitC(Q);
    sclH <= 1'b1; waitC(Q);
    sdaH <= 1'b0; waitC(Q);
    sclH <= 1'b0;
  endtask

  task automatic stopC();
    waitC(Q);
    sdaH <= 1'b0; waitC(Q);
    sclH <= 1'b1; waitC(Q);
    sdaH <= 1'b1; waitC(Q);
  endtask

  task automatic bitOut(input logic b, input int lowStall, input int highStall, input bit glitch);
    waitC(Q);
    sdaH <= b;
    waitC(Q + lowStall);
    sclH <= 1'b1;
    if (glitch) begin
      waitC(Q);
      sclH <= 1'b0; waitC(2);
      sclH <= 1'b1; waitC(Q - 2 + highStall);
    end else begin
      waitC(2 * Q + highStall);
    end
    sclH <= 1'b0;
  endtask

  task automatic bitIn(output logic b);
    waitC(Q);
    sdaH <= 1'b1;
    waitC(Q);
    sclH <= 1'b1;
    waitC(Q);
    #1 b = sdaLine;
    waitC(Q);
    sclH <= 1'b0;
  endtask

  task automatic sendByte(input logic [7:0] d, output logic acked, input int stallBit,
                          input int lowStall, input int highStall, input bit glitch);
    logic b9;
    for (int i = 7; i >= 0; i--)
      bitOut(d[i], (i == stallBit) ? lowStall : 0, (i == stallBit) ? highStall : 0, glitch);
    bitIn(b9);
    acked = !b9;
  endtask

  task automatic recvByte(input bit hostAck, output logic [7:0] d);
    for (int i = 7; i >= 0; i--) bitIn(d[i]);
    bitOut(hostAck ? 1'b0 : 1'b1, 0, 0, 1'b0);
  endtask

  task automatic writeByte(input logic [7:0] a, input logic [7:0] d, output logic [2:0] acks);
    startC();
    sendByte({DEV, 1'b0}, acks[2], -1, 0, 0, 1'b0);
    sendByte(a, acks[1], -1, 0, 0, 1'b0);
    sendByte(d, acks[0], -1, 0, 0, 1'b0);
    stopC();
  endtask

  task automatic readByte(input logic [7:0] a, output logic [7:0] d, output logic [2:0] acks,
                          output logic relOk);
    startC();
    sendByte({DEV, 1'b0}, acks[2], -1, 0, 0, 1'b0);
    sendByte(a, acks[1], -1, 0, 0, 1'b0);
    startC();
    sendByte({DEV, 1'b1}, acks[0], -1, 0, 0, 1'b0);
    recvByte(1'b0, d);
    waitC(Q / 2);
    #1 relOk = !sdaOe;
    stopC();
  endtask

  task automatic t_reset();
    waitC(10);
    #1;
    chk(sdaOe == 1'b0, "R1 sdaOe after reset", int'(sdaOe), 0);
    chk(regWe == 1'b0, "R1 regWe after reset", int'(regWe), 0);
  endtask

  task automatic t_write();
    logic [2:0] acks;
    int w0 = weCnt;
    writeByte(8'h05, 8'hA5, acks);
    waitC(4);
    chk(acks == 3'b111, "R2 write acks", int'(acks), 7);
    chk(weCnt == w0 + 1, "R2 write strobe count", weCnt - w0, 1);
    chk(lastA == 8'h05 && lastD == 8'hA5, "R2 write addr/data", {lastA, lastD}, 16'h05A5);
  endtask

  task automatic t_read();
    logic [2:0] acks; logic [7:0] d; logic rel;
    readByte(8'h05, d, acks, rel);
    chk(acks == 3'b111, "R4 read acks", int'(acks), 7);
    chk(d == 8'hA5, "R4 read data", int'(d), 'hA5);
    chk(rel, "R4 SDA released after NACK", int'(!rel), 0);
  endtask

  task automatic t_wrongAddr();
    logic a0, a1, a2;
    int w0 = weCnt;
    startC();
    sendByte({7'h2E, 1'b0}, a0, -1, 0, 0, 1'b0);
    sendByte(8'h07, a1, -1, 0, 0, 1'b0);
    sendByte(8'h99, a2, -1, 0, 0, 1'b0);
    stopC();
    waitC(4);
    chk(!a0, "R5 wrong address not acked", int'(a0), 0);
    chk(!a1 && !a2, "R5 following bytes not acked", int'({a1, a2}), 0);
    chk(weCnt == w0, "R5 no write strobe", weCnt - w0, 0);
  endtask

  task automatic t_sendRecv();
    logic a0, a1, a2; logic [7:0] d1, d2;
    int w0 = weCnt;
    startC();
    sendByte({DEV, 1'b0}, a0, -1, 0, 0, 1'b0);
    sendByte(8'h33, a1, -1, 0, 0, 1'b0);
    stopC();
    chk(a0 && a1, "R6 send byte acks", int'({a0, a1}), 3);
    chk(weCnt == w0, "R6 send byte writes nothing", weCnt - w0, 0);
    startC();
    sendByte({DEV, 1'b1}, a2, -1, 0, 0, 1'b0);
    recvByte(1'b1, d1);
    recvByte(1'b0, d2);
    stopC();
    chk(a2, "R6 receive address ack", int'(a2), 1);
    chk(d1 == (8'h33 ^ 8'h5A), "R6 receive byte data", int'(d1), int'(8'h33 ^ 8'h5A));
    chk(d2 == d1, "R6 pointer not incremented", int'(d2), int'(d1));
  endtask

  task automatic t_cfgRead(input logic [7:0] exp, input string tag);
    logic [2:0] acks; logic [7:0] d; logic rel;
    readByte(8'h20, d, acks, rel);
    chk(d == exp && acks == 3'b111, tag, int'(d), int'(exp));
  endtask

  task automatic t_cfgWrite();
    logic [2:0] acks;
    int w0 = weCnt;
    writeByte(8'h20, 8'h00, acks);
    waitC(4);
    chk(weCnt == w0, "R7 config write not exported", weCnt - w0, 0);
    t_cfgRead(8'h00, "R7 config readback after clear");
  endtask

  task automatic t_stallWrite(input logic [7:0] a, input logic [7:0] d, input int stallBit,
                              input int lowStall, input int highStall, input bit glitch,
                              output logic [2:0] acks, output int wDelta);
    int w0 = weCnt;
    startC();
    sendByte({DEV, 1'b0}, acks[2], -1, 0, 0, 1'b0);
    sendByte(a, acks[1], -1, 0, 0, 1'b0);
    sendByte(d, acks[0], stallBit, lowStall, highStall, glitch);
    stopC();
    waitC(4);
    wDelta = weCnt - w0;
  endtask

  task automatic t_lowDisabled();
    logic [2:0] acks; int wd;
    t_stallWrite(8'h40, 8'h3C, 3, 400, 0, 1'b0, acks, wd);
    chk(acks == 3'b111 && wd == 1, "R8 long low with timeout off", int'(acks), 7);
    chk(lastD == 8'h3C, "R8 data after stall", int'(lastD), 'h3C);
  endtask

  task automatic t_stopMid();
    logic a0, a1;
    startC();
    sendByte({DEV, 1'b0}, a0, -1, 0, 0, 1'b0);
    stopC();
    // clock a byte with no START after the STOP
    sclH <= 1'b0;
    sendByte({DEV, 1'b0}, a1, -1, 0, 0, 1'b0);
    stopC();
    chk(a0, "R3 address ack before STOP", int'(a0), 1);
    chk(!a1, "R3 no ack without START", int'(a1), 0);
  endtask

  task automatic t_glitch();
    logic [2:0] acks; int wd;
    t_stallWrite(8'h43, 8'h96, -1, 0, 0, 1'b1, acks, wd);
    chk(acks == 3'b111 && wd == 1, "R12 SCL glitches filtered", int'(acks), 7);
    chk(lastA == 8'h43 && lastD == 8'h96, "R12 data intact", {lastA, lastD}, 16'h4396);
  endtask

  task automatic t_lowEnabled();
    logic [2:0] acks; int wd;
    t_stallWrite(8'h41, 8'h77, 5, 400, 0, 1'b0, acks, wd);
    chk(acks[0] == 1'b0, "R9 data not acked after low timeout", int'(acks[0]), 0);
    chk(wd == 0, "R9 no write after low timeout", wd, 0);
  endtask

  task automatic t_idleEnabled();
    logic [2:0] acks; int wd;
    t_stallWrite(8'h42, 8'h66, 6, 0, 200, 1'b0, acks, wd);
    chk(acks[0] == 1'b0, "R10 data not acked after idle timeout", int'(acks[0]), 0);
    chk(wd == 0, "R10 no write after idle timeout", wd, 0);
  endtask

  task automatic t_race();
    logic [2:0] acks;
    for (int k = 0; k < 17; k++) begin
      int w0 = weCnt;
      logic [7:0] a = 8'h60 + 8'(k);
      logic [7:0] d = 8'(k * 7 + 1);
      waitC(IDLE_CYC - 32 + k);
      writeByte(a, d, acks);
      waitC(4);
      chk(acks == 3'b111 && weCnt == w0 + 1 && lastA == a && lastD == d,
          "R11 START against idle expiry", int'(acks), 7);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nBad++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", nChk + 1, nBad);
    $finish;
  end

  initial begin
    waitC(10);
    rstN <= 1'b1;
    t_reset();
    t_write();
    t_read();
    t_wrongAddr();
    t_sendRecv();
    t_cfgRead(8'h01, "R7 config reset value");
    t_lowDisabled();
    t_stopMid();
    t_glitch();
    t_cfgWrite();
    t_lowEnabled();
    t_idleEnabled();
    t_race();
    $display("test done: total=%0d bad=%0d", nChk, nBad);
    $finish;
  end

endmodule